// File: doc/BRIEF.md
# Address-Programmed Wait and Retry Response Generator

This block forms the transfer response of an AHB slave. Each accepted transfer carries its own response program in the address. A four-bit field sets how many wait states the data phase gets. A two-bit field sets how many RETRY responses the master sees before the transfer completes. The block holds two down-counters and drives `hready_out`, a two-bit `hresp` and a `done` strobe. The surrounding register file uses `done` as its write enable.

The address phase is taken when `addr_valid` and `hready_in` are both high. The data phase starts on the next cycle. Wait states count down one per clock. A retry program is loaded only on the first attempt at a given address, so the master's re-issued attempts consume it. RETRY is always given as the two-cycle AHB response. Its code appears only on the final low-ready cycle.

Top module: `ahb_wait_retry_gen`

## Requirements
- R1: While reset is asserted and directly after it, `hready_out` is 1, `hresp` is OKAY (2'b00) and `done` is 0.
- R2: A transfer whose address bits [11:8] hold N (1..15) gets exactly N data-phase cycles with `hready_out` low, followed by one cycle with `hready_out` high.
- R3: A transfer with address bits [11:8] equal to zero completes in its first data-phase cycle with `hready_out` high.
- R4: For a new address with bits [13:12] equal to K and a nonzero wait field, the first K attempts end with RETRY and attempt K+1 ends with OKAY.
- R5: A nonzero retry field [13:12] is ignored when the wait field [11:8] is zero. The transfer completes with OKAY.
- R6: A RETRY is `hresp`=2'b10 with `hready_out` low, then `hresp`=2'b10 with `hready_out` high. Every earlier wait cycle of that data phase shows OKAY.
- R7: The retry count is not reloaded when the same address is issued again. It is reloaded whenever the accepted address differs from the last accepted one.
- R8: `done` is 1 only in the cycle a transfer completes with OKAY. It is never 1 on a RETRY completion or on a wait cycle.
- R9: An address phase with `addr_valid` low or `hready_in` low is ignored. The outputs stay idle: `hready_out` 1, OKAY, `done` 0.
- R10: `hresp` only takes the values OKAY (2'b00) and RETRY (2'b10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_valid | input | 1 | Slave selected with an active transfer in the address phase |
| hready_in | input | 1 | Bus ready; the address phase is taken only when high |
| haddr | input | ADDR_W | Transfer address; [11:8] wait count, [13:12] retry count |
| hready_out | output | 1 | Slave ready; low during wait states and the first RETRY cycle |
| hresp | output | 2 | Response: 2'b00 OKAY, 2'b10 RETRY |
| done | output | 1 | Write enable, high in the OKAY completion cycle |

## Verification
The hardest case to reach is the reload rule for the retry count. An address is retried once and then abandoned for a different address, and the first address must later come back with its full count reloaded. Reaching it from the ports takes a scripted sequence of re-issued attempts that switches address in the middle of a retry program. Each attempt's expected cycles come from a model that tracks the last accepted address and the retries left. Wait fields of 1 and 15 are included, so the RETRY code lands on the only low cycle in one case and on the fifteenth in the other.

// File: rtl/ahb_wait_retry_gen.sv
module ahb_wait_retry_gen #(
  parameter int ADDR_W    = 32,
  parameter int WAIT_LSB  = 8,
  parameter int WAIT_W    = 4,
  parameter int RETRY_LSB = 12,
  parameter int RETRY_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic              hready_in,
  input  logic [ADDR_W-1:0] haddr,
  output logic              hready_out,
  output logic [1:0]        hresp,
  output logic              done
);

  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_RETRY = 2'b10;
  localparam logic [WAIT_W-1:0]  WAIT_ONE   = WAIT_W'(1);
  localparam logic [RETRY_W-1:0] RETRY_ZERO = '0;

  logic              in_data;
  logic [WAIT_W-1:0] wait_cnt;
  logic [RETRY_W-1:0] retry_cnt;
  logic [ADDR_W-1:0] last_addr;

  wire               take      = addr_valid & hready_in;
  wire [WAIT_W-1:0]  wait_fld  = haddr[WAIT_LSB +: WAIT_W];
  wire [RETRY_W-1:0] retry_fld = haddr[RETRY_LSB +: RETRY_W];
  wire               finish    = in_data && (wait_cnt == '0);
  wire               retrying  = retry_cnt != RETRY_ZERO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data   <= 1'b0;
      wait_cnt  <= '0;
      retry_cnt <= '0;
      last_addr <= '0;
    end else begin
      if (in_data && wait_cnt != '0) wait_cnt <= wait_cnt - WAIT_ONE;
      if (finish) begin
        in_data <= 1'b0;
        if (retrying) retry_cnt <= retry_cnt - RETRY_W'(1);
      end
      if (take) begin
        in_data  <= 1'b1;
        wait_cnt <= wait_fld;
        if (haddr != last_addr) begin
          last_addr <= haddr;
          retry_cnt <= (wait_fld != '0) ? retry_fld : RETRY_ZERO;
        end
      end
    end
  end

  assign hready_out = !(in_data && wait_cnt != '0);
  assign hresp      = (in_data && retrying && wait_cnt <= WAIT_ONE) ? RSP_RETRY : RSP_OKAY;
  assign done       = finish && !retrying;

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hresp == RSP_OKAY || hresp == RSP_RETRY);

  p_retry_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp == RSP_RETRY && !hready_out) |=> (hresp == RSP_RETRY && hready_out));

  p_retry_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp == RSP_RETRY && hready_out) |-> $past(hresp == RSP_RETRY && !hready_out));

  p_retry_last_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp == RSP_RETRY && !hready_out) |-> wait_cnt == WAIT_ONE);

  p_done_okay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hready_out && hresp == RSP_OKAY));

  p_no_retry_nowait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_data) && wait_cnt == '0) |-> !retrying);

endmodule

// File: tb/sim_ahb_wait_retry_gen.sv
`timescale 1ns/1ps
module sim_ahb_wait_retry_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0;
  logic        force_low = 1'b0;
  logic [31:0] haddr = '0;
  logic        hready_out, done;
  logic [1:0]  hresp;
  wire         hready_in = force_low ? 1'b0 : hready_out;

  int compared = 0;
  int mismatched = 0;
  logic        mon_on = 1'b0;
  logic [3:0]  exp_q[$];
  int          tag_q[$];
  logic [31:0] m_last = '0;
  int          m_left = 0;

  always #2 clk = ~clk;

  ahb_wait_retry_gen u0 (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .hready_in(hready_in),
    .haddr(haddr), .hready_out(hready_out), .hresp(hresp), .done(done));

  task automatic chk(input int tag, input logic [3:0] got, input logic [3:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL R%0d: got {rdy,resp,done}=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Monitor: one scoreboard item per cycle, idle expected otherwise (R9)
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() > 0) chk(tag_q.pop_front(), {hready_out, hresp, done}, exp_q.pop_front());
      else chk(9, {hready_out, hresp, done}, 4'b1000);
    end
  end

  // Model: R2 wait cycles, R4/R7 retry count, R5 no retry without wait, R6 shape, R8 done, R10 codes
  task automatic push_model(input logic [31:0] a);
    int w = int'(a[11:8]);
    if (a != m_last) begin
      m_last = a;
      m_left = (w != 0) ? int'(a[13:12]) : 0;
    end
    for (int k = 0; k < w; k++) begin
      exp_q.push_back({1'b0, (k == w-1 && m_left != 0) ? 2'b10 : 2'b00, 1'b0});
      tag_q.push_back((k == w-1 && m_left != 0) ? 6 : 2);
    end
    exp_q.push_back({1'b1, (m_left != 0) ? 2'b10 : 2'b00, (m_left == 0)});
    tag_q.push_back((m_left != 0) ? 4 : ((w == 0) ? 3 : 8));
    if (m_left != 0) m_left--;
  endtask

  task automatic xfer(input logic [31:0] a);
    @(negedge clk);
    addr_valid = 1'b1;
    haddr = a;
    @(posedge clk);
    #0.5;
    push_model(a);
    @(negedge clk);
    addr_valid = 1'b0;
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(1, {hready_out, hresp, done}, 4'b1000); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, {hready_out, hresp, done}, 4'b1000); // R1 after reset
    mon_on = 1'b1;
    xfer(32'h0000_0000);                         // R3 zero wait
    xfer(32'h0000_0300);                         // R2 three waits
    xfer(32'h0000_2100);                         // R4 two retries, R6 single low cycle
    xfer(32'h0000_2100);
    xfer(32'h0000_2100);
    xfer(32'h0000_3000);                         // R5 retry field ignored
    xfer(32'h0000_1F00);                         // R6 RETRY on 15th low cycle
    xfer(32'h0000_1F00);
    xfer(32'h0000_3504);                         // R7 abandoned after one retry
    xfer(32'h0000_1204);
    xfer(32'h0000_1204);
    xfer(32'h0000_3504);                         // R7 reloaded: three retries
    xfer(32'h0000_3504);
    xfer(32'h0000_3504);
    xfer(32'h0000_3504);
    xfer(32'h0000_3504);                         // R7 same address, no reload
    @(negedge clk);                              // R9 hready_in low
    force_low = 1'b1; addr_valid = 1'b1; haddr = 32'h0000_1300;
    @(negedge clk);
    force_low = 1'b0; addr_valid = 1'b0;
    haddr = 32'h0000_2700;                       // R9 address without valid
    repeat (4) @(negedge clk);
    xfer(32'h0000_1300);                         // R9 not recorded: retries now
    xfer(32'h0000_1300);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule